// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external 512K x 8 asynchronous static RAM. On the user side it offers a single-request port. Each request carries an address, write data and a read/write select. The controller accepts the request when `req_ready` is high. It finishes the request with a one-cycle `req_ack`, and a read also returns its byte under a one-cycle `rd_valid`.

On the memory side the controller drives three active-low strobes (chip select, output gate and write strobe) and the address bus. The bidirectional data bus is handled as separate output, drive-enable and input signals, and the pad ring combines them. Each bus phase is held for a whole number of clock cycles. These counts are worked out at elaboration from the clock period and the memory's timing windows in picoseconds. Every count is rounded up, with a floor of one cycle.

Writes are framed by the overlap of chip select and write strobe, and the controller keeps output gate high throughout. Reads hold chip select and output gate low for the access window and then release the bus for a turnaround gap. No new cycle can start until that gap has passed.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `req_ack` and `rd_valid` are 0, and `req_ready` is 1.
- R2: `sram_oe_n` and `sram_we_n` are never low together, and neither is low while `sram_ce_n` is high.
- R3: A write drives the address with `sram_ce_n` low for N_AS cycles (1 at default timing) before `sram_we_n` falls. The address does not change while `sram_ce_n` stays low.
- R4: `sram_we_n` stays low for exactly N_WP cycles (2 at default timing), with `sram_ce_n` low throughout.
- R5: The controller drives data only while `sram_we_n` is low and `sram_oe_n` is high. It starts N_WZ cycles (1 at default) after `sram_we_n` falls, and the driven value is the request's write data, held stable until `sram_we_n` rises.
- R6: A write ends with `sram_we_n` and `sram_ce_n` rising on the same edge as `sram_dq_oe` falls. `req_ack` is high for exactly the following cycle.
- R7: A read holds `sram_ce_n` and `sram_oe_n` low for N_RA cycles (2 at default) with the bus undriven. The bus value is registered on the edge that ends this window. `rd_valid` and `req_ack` then pulse together for one cycle, with `rd_data` holding that value.
- R8: After a read, `sram_ce_n` and `sram_oe_n` stay high and the bus stays undriven for N_TA cycles (1 at default) before `req_ready` returns.
- R9: `req_ready` is low from the acceptance edge until the cycle, including turnaround, is finished. A request presented while `req_ready` is low has no effect on the memory.
- R10: At default timing (8000 ps clock), a write occupies 4 cycles and a read 3 cycles from the acceptance edge until `req_ready` is high again. `req_ack` is high in the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | DATA_W | Registered read data |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output gate, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | DATA_W | Data bus output value |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | DATA_W | Data bus input value |

## Verification
The hardest conditions to produce are a request held on the port while the controller is busy, and a read that leads straight into a write, where a late bus release would collide with the next drive. The bench holds `req_valid` high with a different write payload for the whole busy window. It drops the request one cycle before ready returns, then reads that address back to show it was never written. The memory model keeps driving the bus for one cycle after the output gate closes, so any early drive by the controller shows up as contention. Until the access window has elapsed, the model returns the inverse of the stored byte, so a capture on an early edge returns the wrong value.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSET,
      ST_WPUL,
      ST_WEND,
      ST_RACC,
      ST_TURN
   } asram_st_e;

   // whole clock cycles covering a window in picoseconds, never below one
   function automatic int to_cyc(input int win_ps, input int clk_ps);
      int c;
      c = (win_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // strobe low length: own width, late-drive plus setup, and the windows
   // measured from address or select that the setup phase already covers
   function automatic int pulse_len(input int wp, input int wz, input int ds,
                                    input int aw, input int cw, input int wc,
                                    input int as_c);
      int r;
      r = max2(wp, wz + ds);
      r = max2(r, aw - as_c);
      r = max2(r, cw - as_c);
      r = max2(r, wc - as_c - 1);
      return r;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int unsigned CNT_W = 2,
   parameter int unsigned N_MAX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (N_MAX <= 1) begin : g_flat
         // every phase is one cycle long: the count never leaves zero
         assign cnt = '0;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (start)
               cnt_q <= '0;
            else if (cnt_q != {CNT_W{1'b1}})
               cnt_q <= cnt_q + 1'b1;
         end
         assign cnt = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned CNT_W = 2,
   parameter int unsigned N_AS  = 1,
   parameter int unsigned N_WZ  = 1,
   parameter int unsigned N_WP  = 2,
   parameter int unsigned N_RA  = 2,
   parameter int unsigned N_TA  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [CNT_W-1:0] cnt,
   output logic             tmr_start,
   output logic             accept,
   output logic             capture,
   output logic             ready,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe,
   output logic             ack,
   output logic             rd_valid
);

   localparam logic [CNT_W-1:0] LAST_AS   = CNT_W'(N_AS - 1);
   localparam logic [CNT_W-1:0] LAST_WP   = CNT_W'(N_WP - 1);
   localparam logic [CNT_W-1:0] LAST_RA   = CNT_W'(N_RA - 1);
   localparam logic [CNT_W-1:0] LAST_TA   = CNT_W'(N_TA - 1);
   localparam logic [CNT_W-1:0] FIRST_DRV = CNT_W'(N_WZ);

   asram_st_e        state_q, state_nxt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             drive_nxt;
   logic             wend_entry;

   always_comb begin
      state_nxt = state_q;
      tmr_start = 1'b0;
      accept    = 1'b0;
      capture   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            accept    = 1'b1;
            tmr_start = 1'b1;
            state_nxt = req_write ? ST_WSET : ST_RACC;
         end
         ST_WSET: if (cnt == LAST_AS) begin
            tmr_start = 1'b1;
            state_nxt = ST_WPUL;
         end
         ST_WPUL: if (cnt == LAST_WP) begin
            tmr_start = 1'b1;
            state_nxt = ST_WEND;
         end
         ST_WEND: begin
            tmr_start = 1'b1;
            state_nxt = ST_IDLE;
         end
         ST_RACC: if (cnt == LAST_RA) begin
            tmr_start = 1'b1;
            capture   = 1'b1;
            state_nxt = ST_TURN;
         end
         ST_TURN: if (cnt == LAST_TA) begin
            tmr_start = 1'b1;
            state_nxt = ST_IDLE;
         end
         default: begin
            tmr_start = 1'b1;
            state_nxt = ST_IDLE;
         end
      endcase
   end

   // count the next cycle will see, used to delay the data drive inside the pulse
   always_comb begin
      cnt_nxt    = tmr_start ? '0 : cnt + 1'b1;
      drive_nxt  = (state_nxt == ST_WPUL) && (cnt_nxt >= FIRST_DRV);
      wend_entry = (state_nxt == ST_WEND) && (state_q != ST_WEND);
   end

   // strobes are flops loaded from the next state: no decode glitches on the pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ce_n     <= 1'b1;
         oe_n     <= 1'b1;
         we_n     <= 1'b1;
         dq_oe    <= 1'b0;
         ack      <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         state_q  <= state_nxt;
         ce_n     <= !(state_nxt == ST_WSET || state_nxt == ST_WPUL ||
                       state_nxt == ST_RACC);
         oe_n     <= !(state_nxt == ST_RACC);
         we_n     <= !(state_nxt == ST_WPUL);
         dq_oe    <= drive_nxt;
         ack      <= wend_entry || capture;
         rd_valid <= capture;
      end
   end

   assign ready = (state_q == ST_IDLE);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (accept) begin
         mem_addr  <= req_addr;
         mem_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (capture)
         rdata <= dq_in;
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 8,
   parameter int          CLK_PS    = 8000,
   parameter int          T_AS_PS   = 0,
   parameter int          T_WP_PS   = 7000,
   parameter int          T_AW_PS   = 7000,
   parameter int          T_CW_PS   = 7000,
   parameter int          T_DS_PS   = 6000,
   parameter int          T_WC_PS   = 10000,
   parameter int          T_HZWE_PS = 6000,
   parameter int          T_AA_PS   = 10000,
   parameter int          T_OE_PS   = 5000,
   parameter int          T_RC_PS   = 10000,
   parameter int          T_HZ_PS   = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              req_ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_i
);

   localparam int N_AS  = to_cyc(T_AS_PS, CLK_PS);
   localparam int N_WZ  = to_cyc(T_HZWE_PS, CLK_PS);
   localparam int N_DS  = to_cyc(T_DS_PS, CLK_PS);
   localparam int N_WP  = pulse_len(to_cyc(T_WP_PS, CLK_PS), N_WZ, N_DS,
                                    to_cyc(T_AW_PS, CLK_PS),
                                    to_cyc(T_CW_PS, CLK_PS),
                                    to_cyc(T_WC_PS, CLK_PS), N_AS);
   localparam int N_RA  = max2(max2(to_cyc(T_AA_PS, CLK_PS),
                                    to_cyc(T_OE_PS, CLK_PS)),
                               to_cyc(T_RC_PS, CLK_PS));
   localparam int N_TA  = to_cyc(T_HZ_PS, CLK_PS);
   localparam int N_MAX = max2(max2(N_AS, N_WP), max2(N_RA, N_TA));
   localparam int CNT_W = max2(1, $clog2(N_MAX + 1));

   initial begin
      if (ADDR_W < 1 || DATA_W < 1)
         $fatal(1, "asram_ctrl: bus widths must be at least one bit");
      if (CLK_PS < 1)
         $fatal(1, "asram_ctrl: clock period must be positive");
      if (N_WP < N_WZ + N_DS)
         $fatal(1, "asram_ctrl: pulse too short for late drive plus setup");
   end

   logic             tmr_start;
   logic             accept;
   logic             capture;
   logic [CNT_W-1:0] cnt;

   asram_timer #(
      .CNT_W (CNT_W),
      .N_MAX (N_MAX)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .cnt   (cnt)
   );

   asram_seq #(
      .CNT_W (CNT_W),
      .N_AS  (N_AS),
      .N_WZ  (N_WZ),
      .N_WP  (N_WP),
      .N_RA  (N_RA),
      .N_TA  (N_TA)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .cnt       (cnt),
      .tmr_start (tmr_start),
      .accept    (accept),
      .capture   (capture),
      .ready     (req_ready),
      .ce_n      (sram_ce_n),
      .oe_n      (sram_oe_n),
      .we_n      (sram_we_n),
      .dq_oe     (sram_dq_oe),
      .ack       (req_ack),
      .rd_valid  (rd_valid)
   );

   asram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (sram_dq_i),
      .mem_addr  (sram_addr),
      .mem_wdata (sram_dq_o),
      .rdata     (rd_data)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8,
   parameter int          N_WP   = 2,
   parameter int          N_RA   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              req_ack,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic [DATA_W-1:0] sram_dq_o,
   input logic              sram_dq_oe
);

   int we_low_cnt;
   int oe_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= 0;
         oe_low_cnt <= 0;
      end else begin
         we_low_cnt <= sram_we_n ? 0 : we_low_cnt + 1;
         oe_low_cnt <= sram_oe_n ? 0 : oe_low_cnt + 1;
      end
   end

   a_r2_no_gate_and_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_oe_n && !sram_we_n));

   a_r2_select_covers_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n || !sram_oe_n) |-> !sram_ce_n);

   a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_low_cnt == N_WP));

   a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_we_n && sram_oe_n));

   a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

   a_r6_end_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (sram_ce_n && !sram_dq_oe && req_ack));

   a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   a_r7_read_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (oe_low_cnt == N_RA && rd_valid && req_ack));

   a_r7_valid_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> req_ack);

   a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (!req_ready && !sram_dq_oe));

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce_n |-> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .N_WP   (N_WP),
   .N_RA   (N_RA)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .req_ack    (req_ack),
   .rd_valid   (rd_valid),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .sram_dq_o  (sram_dq_o),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

   localparam int AW     = 19;
   localparam int DW     = 8;
   localparam int WR_LEN = 4;   // R10 write occupancy
   localparam int RD_LEN = 3;   // R10 read occupancy
   localparam logic [AW-1:0] POKE_A = 19'h2_5A5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, req_ack, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_o;
   logic [DW-1:0] sram_dq_i = '0;

   int checks = 0;
   int errors = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   asram_ctrl uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .req_ready (req_ready), .req_ack (req_ack),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .sram_addr (sram_addr), .sram_ce_n (sram_ce_n),
      .sram_oe_n (sram_oe_n), .sram_we_n (sram_we_n),
      .sram_dq_o (sram_dq_o), .sram_dq_oe (sram_dq_oe),
      .sram_dq_i (sram_dq_i)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory with window checks ----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] sb  [int];
   bit            p_ce_n = 1, p_we_n = 1, tail = 0, p_drv = 0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_dq = '0;
   int            rd_low = 0, we_low = 0;

   always @(negedge clk) begin
      if (model_on) begin
         bit          mdrv;
         logic [DW-1:0] word;
         mdrv = !sram_ce_n && !sram_oe_n && sram_we_n;
         if ((mdrv || tail) && sram_dq_oe)
            chk(1'b0, "R8 bus contention", 1, 0);
         if (!sram_ce_n && !p_ce_n && sram_addr != p_addr)
            chk(1'b0, "R3 address moved under select", int'(sram_addr), int'(p_addr));
         if (!sram_we_n && p_we_n) begin
            chk(!p_ce_n, "R3 select before strobe", int'(p_ce_n), 0);
            chk(!sram_dq_oe, "R5 no drive in first pulse cycle", int'(sram_dq_oe), 0);
         end
         if (sram_we_n && !p_we_n) begin
            chk(we_low == 2, "R4 strobe width", we_low, 2);
            chk(p_drv, "R5 data set up before write end", int'(p_drv), 1);
            chk(sram_ce_n, "R6 select ends with strobe", int'(sram_ce_n), 1);
            if (p_drv) mem[int'(p_addr)] = p_dq;
         end
         we_low = sram_we_n ? 0 : we_low + 1;
         rd_low = mdrv ? rd_low + 1 : 0;
         tail   = mdrv;
         word   = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : '0;
         sram_dq_i = (rd_low >= 2) ? word : ~word;
         p_ce_n = sram_ce_n;
         p_we_n = sram_we_n;
         p_addr = sram_addr;
         p_drv  = sram_dq_oe;
         p_dq   = sram_dq_o;
      end
   end

   // ---------------- one request, checked every cycle ----------------
   task automatic do_op(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit poke);
      int len;
      logic [DW-1:0] exp_rd;
      len = wr ? WR_LEN : RD_LEN;
      exp_rd = sb.exists(int'(a)) ? sb[int'(a)] : '0;
      @(negedge clk);
      chk(req_ready, "R9 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      if (poke) begin
         req_write = 1'b1; req_addr = POKE_A; req_wdata = 8'hEE;
      end else req_valid = 1'b0;
      for (int k = 0; k < len; k++) begin
         if (k > 0) @(negedge clk);
         if (poke && k == len - 1) req_valid = 1'b0;
         chk(!req_ready, "R9 busy", int'(req_ready), 0);
         chk(req_ack == (k == len - 1), "R10 ack placement", int'(req_ack), int'(k == len - 1));
         chk(rd_valid == (!wr && k == len - 1), "R7 rd_valid placement",
             int'(rd_valid), int'(!wr && k == len - 1));
         if (wr) begin
            chk(sram_ce_n == (k == 3), "R3 select phase", int'(sram_ce_n), int'(k == 3));
            chk(sram_we_n == (k == 0 || k == 3), "R4 strobe phase",
                int'(sram_we_n), int'(k == 0 || k == 3));
            chk(sram_dq_oe == (k == 2), "R5 drive phase", int'(sram_dq_oe), int'(k == 2));
            chk(sram_oe_n, "R2 gate high in write", int'(sram_oe_n), 1);
            if (k < 3) chk(sram_addr == a, "R3 address value", int'(sram_addr), int'(a));
            if (k == 2) chk(sram_dq_o == d, "R5 drive value", int'(sram_dq_o), int'(d));
         end else begin
            chk(sram_ce_n == (k == 2), "R7 select phase", int'(sram_ce_n), int'(k == 2));
            chk(sram_oe_n == (k == 2), "R8 gate phase", int'(sram_oe_n), int'(k == 2));
            chk(!sram_dq_oe && sram_we_n, "R7 bus undriven", int'(sram_dq_oe), 0);
            if (k == 2) chk(rd_data == exp_rd, "R7 read data", int'(rd_data), int'(exp_rd));
         end
      end
      @(negedge clk);
      chk(req_ready, "R10 ready after cycle", int'(req_ready), 1);
      chk(!req_ack && !rd_valid, "R6 ack single cycle", int'(req_ack), 0);
      if (poke) chk(sram_ce_n, "R9 held request not started", int'(sram_ce_n), 1);
      if (wr) sb[int'(a)] = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] slot [8];
      repeat (3) @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes in reset",
          int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
      chk(!sram_dq_oe, "R1 no drive in reset", int'(sram_dq_oe), 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);
      chk(req_ready && !req_ack && !rd_valid, "R1 idle after reset",
          int'({req_ready, req_ack, rd_valid}), 4);
      chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R2 deselected idle",
          int'({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}), 14);

      // boundary addresses and data
      do_op(1'b1, 19'h0_0000, 8'h00, 1'b0);
      do_op(1'b1, 19'h7_FFFF, 8'hFF, 1'b0);
      do_op(1'b0, 19'h0_0000, 8'h00, 1'b0);
      do_op(1'b0, 19'h7_FFFF, 8'h00, 1'b0);
      // held request while busy must be ignored (R9)
      do_op(1'b1, POKE_A, 8'h33, 1'b0);
      do_op(1'b1, 19'h1_2345, 8'hC3, 1'b1);
      do_op(1'b0, 19'h0_0000, 8'h00, 1'b1);
      do_op(1'b0, POKE_A, 8'h00, 1'b0);
      chk(mem[int'(POKE_A)] == 8'h33, "R9 held write has no effect",
          int'(mem[int'(POKE_A)]), 8'h33);
      // read followed by write exercises turnaround (R8)
      do_op(1'b0, 19'h1_2345, 8'h00, 1'b0);
      do_op(1'b1, 19'h1_2345, 8'h5A, 1'b0);
      do_op(1'b0, 19'h1_2345, 8'h00, 1'b0);

      for (int i = 0; i < 8; i++) begin
         slot[i] = AW'($urandom);
         do_op(1'b1, slot[i], DW'($urandom), 1'b0);
      end
      for (int n = 0; n < 80; n++) begin
         int s;
         s = int'($urandom % 8);
         do_op(1'(($urandom % 3) == 0), slot[s], DW'($urandom), 1'b0);
      end
      for (int i = 0; i < 8; i++)
         chk(mem[int'(slot[i])] == sb[int'(slot[i])], "R5 stored byte",
             int'(mem[int'(slot[i])]), int'(sb[int'(slot[i])]));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule